// File: doc/BRIEF.md
# System Tick Compare Timer

This block keeps a 63-bit system tick count that advances by one on every clock, and two compare registers that turn a chosen count value into an interrupt event. One compare register belongs to privileged software and the other to the hypervisor. Each compare register is 64 bits wide: the top bit (bit 63) is a disable flag and the low 63 bits hold the target count.

A compare is armed at the moment software writes it, and only when its disable flag is clear and its target lies strictly ahead of the count seen in the write cycle. An armed compare fires once, in the clock edge where the count becomes equal to its target, and is then spent. A privileged match produces a one-cycle request to set bit 16 of the soft interrupt register. A hypervisor match sets a sticky interrupt-pending flag, which software can read and overwrite. The hypervisor compare is silenced while the thread is halted; a suspended thread still receives both kinds of match, since a match is what wakes it.

Software reaches the count, both compare registers and the pending flag through one write port and one combinational read port, selected by a 2-bit register index.

Top module: `tick_cmp_timer`

## Requirements
- R1: While reset is held, the count reads 0, both compare registers read 0x8000_0000_0000_0000 (disabled, target 0), the pending flag reads 0 and `soft_req_o` is low.
- R2: Register index 0 is the count; a write loads the count with bits 62:0 of the data, which reads back after that edge and advances by exactly one per clock after it.
- R3: The count wraps from 0x7FFF_FFFF_FFFF_FFFF to 0 on the next clock.
- R4: Writing index 1 (privileged compare) with bit 63 clear and a target greater than the count in the write cycle makes `soft_req_o` high for exactly one cycle, the cycle in which the count reads the target; this includes a target one above the count, which fires at the write edge itself.
- R5: A compare register written with bit 63 set produces no match, whatever its target.
- R6: A compare written with a target equal to or below the count in the write cycle is not armed, and produces no match even if the count is later moved below the target and climbs past it.
- R7: Rewriting a compare register cancels any match armed by the earlier value; only the new value can produce a match.
- R8: Each armed compare fires at most once; moving the count back below a target that already fired gives no second match.
- R9: Writing index 2 (hypervisor compare) arms it by the same rules; its match sets `hyp_pend_o` to 1, which then holds. Writing index 3 sets the flag to data bit 0, and a match in the same edge as such a write leaves the flag at 1.
- R10: With `thr_state_i` = 2'b10 (halted) a hypervisor match is dropped and spent: the flag is not set then nor after the thread leaves the halted state. The privileged compare is not affected by the thread state.
- R11: With `thr_state_i` = 2'b01 (suspended) both compares still deliver their match; 2'b00 is running.
- R12: Reading index 1 or 2 returns the 64-bit value last written, disable flag included; reading index 3 returns the pending flag in bit 0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register index (0 count, 1 privileged compare, 2 hypervisor compare, 3 pending flag) |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 2 | Read register index, same encoding |
| rd_data_o | output | 64 | Read data, combinational from the register state |
| thr_state_i | input | 2 | Thread state: 00 running, 01 suspended, 10 halted |
| soft_req_o | output | 1 | One-cycle request to set soft interrupt bit 16 |
| hyp_pend_o | output | 1 | Hypervisor interrupt-pending flag |

## Verification
Every result is registered in the same edge that makes the count equal to the target, so a match is visible in the very cycle the count reads the target; a target one above the count therefore fires at the write edge, and a target N ahead fires N-1 edges after the write. The bench avoids counting edges by hand for each case: it samples once per cycle between edges and records the count shown at each request pulse and at each rise of the pending flag, then checks both the number of events and the count they coincide with. The priority case of a pending-flag write landing on a match edge is timed by placing one idle cycle between the compare write and the flag write.

// File: rtl/tct_pkg.sv
package tct_pkg;

    // Register index decoded on both the write and the read port.
    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_PCMP  = 2'd1,
        REG_HCMP  = 2'd2,
        REG_HPEND = 2'd3
    } tct_reg_e;

    // Execution state of the thread served by this timer.
    typedef enum logic [1:0] {
        THR_RUN  = 2'd0,
        THR_SUSP = 2'd1,
        THR_HALT = 2'd2,
        THR_RSVD = 2'd3
    } tct_thr_e;

    // Index of each comparator in the generate array.
    localparam int unsigned CMP_PRIV = 0;
    localparam int unsigned CMP_HYP  = 1;
    localparam int unsigned NUM_CMP  = 2;

endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
    parameter int unsigned CNT_W = 63
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // Next count: a load replaces the increment; the add wraps by width.
    always_comb begin
        st_d = st_q;
        if (load_en_i) begin
            st_d.cnt = load_val_i;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

endmodule

// File: rtl/tct_cmp.sv
module tct_cmp #(
    parameter int unsigned CNT_W = 63,
    localparam int unsigned REG_W = CNT_W + 1,
    localparam int unsigned DIS_BIT = CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_val_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_d_i,
    input  logic             deliver_i,
    output logic [REG_W-1:0] reg_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [REG_W-1:0] cmp;
        logic             armed;
        logic             hit;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    logic             arm_now;
    logic [CNT_W-1:0] target;
    logic             at_target;

    always_comb begin
        st_d = st_q;

        // A write decides arming afresh against the count of this cycle and
        // discards whatever the earlier value had armed.
        if (wr_en_i) begin
            st_d.cmp = wr_val_i;
            target   = wr_val_i[CNT_W-1:0];
            arm_now  = !wr_val_i[DIS_BIT] && (wr_val_i[CNT_W-1:0] > cnt_q_i);
        end else begin
            target   = st_q.cmp[CNT_W-1:0];
            arm_now  = st_q.armed;
        end

        // Equality against the value the count takes at this edge, so the
        // event lines up with the cycle where the count shows the target.
        at_target = arm_now && (target == cnt_d_i);

        // Reaching the target spends the arm even when delivery is blocked.
        st_d.armed = arm_now && !at_target;
        st_d.hit   = at_target && deliver_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cmp   <= {1'b1, {CNT_W{1'b0}}};
            st_q.armed <= 1'b0;
            st_q.hit   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_o = st_q.cmp;
    assign hit_o = st_q.hit;

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tct_pkg::*;
#(
    parameter int unsigned CNT_W = 63,
    localparam int unsigned DATA_W = CNT_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [1:0]        thr_state_i,
    output logic              soft_req_o,
    output logic              hyp_pend_o
);

    typedef struct packed {
        logic pend;
    } top_state_t;

    top_state_t st_d, st_q;

    tct_reg_e         wsel, rsel;
    tct_thr_e         thr;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic [DATA_W-1:0] cmp_reg [NUM_CMP];
    logic              cmp_hit [NUM_CMP];

    assign wsel     = tct_reg_e'(wr_addr_i);
    assign rsel     = tct_reg_e'(rd_addr_i);
    assign thr      = tct_thr_e'(thr_state_i);
    assign cnt_load = wr_en_i && (wsel == REG_COUNT);

    tct_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_en_i  (cnt_load),
        .load_val_i (wr_data_i[CNT_W-1:0]),
        .cnt_q_o    (cnt_q),
        .cnt_d_o    (cnt_d)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam tct_reg_e MY_REG = (g == CMP_PRIV) ? REG_PCMP : REG_HCMP;
        logic wr_sel;
        logic deliver;

        assign wr_sel = wr_en_i && (wsel == MY_REG);

        // The hypervisor event is dropped while halted; the privileged one
        // is never gated by the thread state.
        if (g == CMP_HYP) begin : g_gate
            assign deliver = (thr != THR_HALT);
        end else begin : g_nogate
            assign deliver = 1'b1;
        end

        tct_cmp #(
            .CNT_W (CNT_W)
        ) u_cmp (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_sel),
            .wr_val_i  (wr_data_i),
            .cnt_q_i   (cnt_q),
            .cnt_d_i   (cnt_d),
            .deliver_i (deliver),
            .reg_o     (cmp_reg[g]),
            .hit_o     (cmp_hit[g])
        );
    end

    // Pending flag: a software write sets it to data bit 0; a match that
    // lands in the same edge wins.
    always_comb begin
        st_d = st_q;
        if (wr_en_i && (wsel == REG_HPEND)) begin
            st_d.pend = wr_data_i[0];
        end
        if (g_cmp[CMP_HYP].u_cmp.st_d.hit) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rsel)
            REG_COUNT: rd_data_o = {1'b0, cnt_q};
            REG_PCMP:  rd_data_o = cmp_reg[CMP_PRIV];
            REG_HCMP:  rd_data_o = cmp_reg[CMP_HYP];
            REG_HPEND: rd_data_o = {{(DATA_W-1){1'b0}}, st_q.pend};
            default:   rd_data_o = '0;
        endcase
    end

    assign soft_req_o = cmp_hit[CMP_PRIV];
    assign hyp_pend_o = st_q.pend;

endmodule

// File: rtl/tct_chk.sv
module tct_chk #(
    parameter int unsigned CNT_W = 63
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [1:0]       thr_state_i,
    input logic             soft_req_o,
    input logic             hyp_pend_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W:0]   pcmp
);

    // R2: without a count load the count moves up by exactly one.
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == 2'd0) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R4: the request appears only in the cycle showing the target.
    a_r4_pulse_at_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_req_o |-> (cnt == pcmp[CNT_W-1:0]));

    // R8: a request never lasts two cycles.
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_req_o |=> !soft_req_o);

    // R5: a disabled privileged compare stays silent.
    a_r5_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pcmp[CNT_W] |-> !soft_req_o);

    // R9: the pending flag holds until software writes its register.
    a_r9_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hyp_pend_o && !(wr_en_i && wr_addr_i == 2'd3)) |=> hyp_pend_o);

    // R10: while halted, a clear flag can only be set by a software write.
    a_r10_halt_no_hyp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(thr_state_i) == 2'b10 && !$past(hyp_pend_o)
         && !$past(wr_en_i && wr_addr_i == 2'd3)) |-> !hyp_pend_o);

endmodule

bind tick_cmp_timer tct_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .thr_state_i (thr_state_i),
    .soft_req_o  (soft_req_o),
    .hyp_pend_o  (hyp_pend_o),
    .cnt         (cnt_q),
    .pcmp        (cmp_reg[0])
);

// File: tb/tick_cmp_timer_tb_top.sv
module tick_cmp_timer_tb_top;

    localparam logic [63:0] DIS  = 64'h8000_0000_0000_0000;
    localparam logic [62:0] MAXC = {63{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [63:0] rd_data;
    logic [1:0]  thr = 2'b00;
    logic        soft_req;
    logic        hyp_pend;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tick_cmp_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .thr_state_i (thr),
        .soft_req_o  (soft_req),
        .hyp_pend_o  (hyp_pend)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Called at a falling edge; returns at the falling edge after the write.
    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        rd_addr = a; #1; d = rd_data; rd_addr = 2'd0; #1;
    endtask

    // Samples n cycles between edges; counts request pulses and flag rises.
    task automatic watch(input int n, output int np, output logic [62:0] p_at,
                         output int nh, output logic [62:0] h_at);
        logic hprev;
        np = 0; nh = 0; p_at = '0; h_at = '0; hprev = hyp_pend;
        for (int i = 0; i < n; i++) begin
            if (soft_req) begin np++; p_at = rd_data[62:0]; end
            if (hyp_pend && !hprev) begin nh++; h_at = rd_data[62:0]; end
            hprev = hyp_pend;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(2'd0, v); check(v == 64'd0, "R1 count", v, 64'd0);
        rd(2'd1, v); check(v == DIS, "R1 priv compare", v, DIS);
        rd(2'd2, v); check(v == DIS, "R1 hyp compare", v, DIS);
        rd(2'd3, v); check(v == 64'd0, "R1 pending", v, 64'd0);
        check(soft_req == 1'b0, "R1 soft_req", {63'd0, soft_req}, 64'd0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        wr(2'd0, 64'd1000);
        rd(2'd0, v); check(v == 64'd1000, "R2 load", v, 64'd1000);
        repeat (6) @(negedge clk);
        rd(2'd0, v); check(v == 64'd1006, "R2 step", v, 64'd1006);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        wr(2'd0, {1'b0, MAXC - 63'd1});
        @(negedge clk);
        rd(2'd0, v); check(v == {1'b0, MAXC}, "R3 top", v, {1'b0, MAXC});
        @(negedge clk);
        rd(2'd0, v); check(v == 64'd0, "R3 wrap", v, 64'd0);
        @(negedge clk);
        rd(2'd0, v); check(v == 64'd1, "R3 after wrap", v, 64'd1);
    endtask

    task automatic t_priv();
        int np, nh; logic [62:0] pa, ha;
        wr(2'd0, 64'd100); wr(2'd1, 64'd105);
        watch(20, np, pa, nh, ha);
        check(np == 1, "R4 pulse count", 64'(np), 64'd1);
        check(pa == 63'd105, "R4 pulse cycle", {1'b0, pa}, 64'd105);
        check(nh == 0, "R5 hyp disabled from reset", 64'(nh), 64'd0);
        wr(2'd0, 64'd300); wr(2'd1, 64'd301);
        watch(10, np, pa, nh, ha);
        check(np == 1 && pa == 63'd301, "R4 one ahead", {1'b0, pa}, 64'd301);
    endtask

    task automatic t_disable();
        int np, nh; logic [62:0] pa, ha;
        wr(2'd0, 64'd400); wr(2'd1, DIS | 64'd405);
        watch(20, np, pa, nh, ha);
        check(np == 0, "R5 disabled", 64'(np), 64'd0);
    endtask

    task automatic t_behind();
        int np, nh; logic [62:0] pa, ha;
        wr(2'd0, 64'd500); wr(2'd1, 64'd500); wr(2'd0, 64'd450);
        watch(80, np, pa, nh, ha);
        check(np == 0, "R6 equal target", 64'(np), 64'd0);
        wr(2'd0, 64'd500); wr(2'd1, 64'd490); wr(2'd0, 64'd450);
        watch(80, np, pa, nh, ha);
        check(np == 0, "R6 behind target", 64'(np), 64'd0);
    endtask

    task automatic t_rewrite();
        int np, nh; logic [62:0] pa, ha;
        wr(2'd0, 64'd600); wr(2'd1, 64'd610); wr(2'd1, 64'd620);
        watch(40, np, pa, nh, ha);
        check(np == 1 && pa == 63'd620, "R7 new target only", {1'b0, pa}, 64'd620);
        wr(2'd0, 64'd700); wr(2'd1, 64'd710); wr(2'd1, DIS | 64'd710);
        watch(30, np, pa, nh, ha);
        check(np == 0, "R7 cancel by disabled rewrite", 64'(np), 64'd0);
    endtask

    task automatic t_once();
        int np, nh; logic [62:0] pa, ha;
        wr(2'd0, 64'd800); wr(2'd1, 64'd805);
        watch(15, np, pa, nh, ha);
        check(np == 1, "R8 first match", 64'(np), 64'd1);
        wr(2'd0, 64'd790);
        watch(30, np, pa, nh, ha);
        check(np == 0, "R8 no second match", 64'(np), 64'd0);
    endtask

    task automatic t_hyp();
        int np, nh; logic [62:0] pa, ha; logic [63:0] v;
        wr(2'd0, 64'd900); wr(2'd2, 64'd906);
        watch(20, np, pa, nh, ha);
        check(nh == 1 && ha == 63'd906, "R9 flag set at target", {1'b0, ha}, 64'd906);
        check(hyp_pend == 1'b1, "R9 flag holds", {63'd0, hyp_pend}, 64'd1);
        wr(2'd3, 64'd0);
        check(hyp_pend == 1'b0, "R9 write 0", {63'd0, hyp_pend}, 64'd0);
        wr(2'd3, 64'd1);
        rd(2'd3, v); check(v == 64'd1, "R12 pending read", v, 64'd1);
        wr(2'd3, 64'd0);
        wr(2'd0, 64'd1000); wr(2'd2, 64'd1003);
        @(negedge clk);
        wr(2'd3, 64'd0);
        check(hyp_pend == 1'b1, "R9 match beats write", {63'd0, hyp_pend}, 64'd1);
        wr(2'd3, 64'd0);
    endtask

    task automatic t_halt();
        int np, nh; logic [62:0] pa, ha;
        thr = 2'b10;
        wr(2'd0, 64'd1100); wr(2'd2, 64'd1105); wr(2'd1, 64'd1108);
        watch(20, np, pa, nh, ha);
        check(nh == 0, "R10 halted drops hyp", 64'(nh), 64'd0);
        check(np == 1 && pa == 63'd1108, "R10 priv ungated", {1'b0, pa}, 64'd1108);
        thr = 2'b00;
        watch(10, np, pa, nh, ha);
        check(hyp_pend == 1'b0, "R10 spent after halt", {63'd0, hyp_pend}, 64'd0);
    endtask

    task automatic t_susp();
        int np, nh; logic [62:0] pa, ha;
        thr = 2'b01;
        wr(2'd0, 64'd1200); wr(2'd2, 64'd1204); wr(2'd1, 64'd1206);
        watch(20, np, pa, nh, ha);
        check(nh == 1 && ha == 63'd1204, "R11 hyp while suspended", {1'b0, ha}, 64'd1204);
        check(np == 1 && pa == 63'd1206, "R11 priv while suspended", {1'b0, pa}, 64'd1206);
        thr = 2'b00;
        wr(2'd3, 64'd0);
    endtask

    task automatic t_readback();
        logic [63:0] v;
        wr(2'd1, 64'h0123_4567_89ab_cdef);
        rd(2'd1, v); check(v == 64'h0123_4567_89ab_cdef, "R12 priv read", v, 64'h0123_4567_89ab_cdef);
        wr(2'd2, 64'h8000_0000_0000_0042);
        rd(2'd2, v); check(v == 64'h8000_0000_0000_0042, "R12 hyp read", v, 64'h8000_0000_0000_0042);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_count();
        t_wrap();
        t_priv();
        t_disable();
        t_behind();
        t_rewrite();
        t_once();
        t_hyp();
        t_halt();
        t_susp();
        t_readback();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
            $finish;
        end
    end

endmodule